// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

A four-bit counter driven by two separate count inputs: a rising edge on the up input adds one and a rising edge on the down input subtracts one. Each input counts only while the other one is held high. A parameter picks the modulus: decade, which counts 0 to 9, or binary, which counts 0 to 15. An active-high clear forces the count to zero. An active-low load enable makes the outputs follow four parallel preset inputs. Both take effect on the outputs at once, without waiting for any clock.

Active-low carry and borrow outputs let stages be chained. The carry output of one stage drives the up input of the next, and the borrow output drives the down input. A free-running system clock samples both count inputs through a synchronizer and detects their rising edges. All counting is therefore synchronous to that clock.

Top module: `updn_dual_ctr`

## Requirements
- R1: While `clear` is high, `q` is 0 at once, independent of the clock. Clear takes priority over load and over counting.
- R2: While `load_n` is low and `clear` is low, `q` equals `jam` at once and follows it. Count edges that arrive during load are dropped. After `load_n` returns high, counting resumes from the last loaded value.
- R3: A rise of `up_in` while `dn_in` is high adds one to the count. The new value appears after the third rising edge of `clk` that follows the change.
- R4: A rise of `dn_in` while `up_in` is high subtracts one from the count, with the same three-edge latency.
- R5: A rise of either count input while the other input is low leaves the count unchanged.
- R6: If both count inputs rise within the same `clk` period, the count is unchanged.
- R7: Decade mode (DECADE=1): counting up from 9, or from any loaded code above 9, gives 0. Counting down from 0 gives 9. Counting down from any other value subtracts one.
- R8: Binary mode (DECADE=0): counting up from 15 gives 0, and counting down from 0 gives 15.
- R9: `carry_n` is low exactly when `q` equals the top value (9 or 15) and `up_in` is low. It is evaluated combinationally at the ports.
- R10: `borrow_n` is low exactly when `q` is 0 and `dn_in` is low.
- R11: A count input held high through clear causes no count when clear is released. The synchronizer idles at the high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| clear | input | 1 | Asynchronous master clear, active high |
| load_n | input | 1 | Asynchronous parallel load enable, active low |
| jam | input | 4 | Parallel preset value |
| up_in | input | 1 | Count-up edge input |
| dn_in | input | 1 | Count-down edge input |
| q | output | 4 | Current count |
| carry_n | output | 1 | Active-low carry to the next stage's up input |
| borrow_n | output | 1 | Active-low borrow to the next stage's down input |

## Verification
Three pairs of functions can fall in the same `clk` period: clear with load, load with a qualified count edge, and an up edge with a down edge. The bench provokes each pair deliberately. It raises clear while load is low. It toggles the count inputs during a load and changes `jam` mid-load. It raises both inputs in the same period. A behavioural model keeps a short history of the sampled inputs and the priority order clear, then load, then count. The outputs of a decade instance and a binary instance are compared with this model every clock.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clear,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] sync_d, sync_q;

    // shift chain: bit 0 takes the raw input, last bit is the delayed copy
    always_comb begin
        sync_d = {sync_q[CHAIN-2:0], din};
    end

    // idle level is high so a line held high through clear is no edge
    always_ff @(posedge clk or posedge clear) begin
        if (clear) sync_q <= '1;
        else       sync_q <= sync_d;
    end

    assign level = sync_q[STAGES-1];
    assign rise  = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/updn_step_sel.sv
module updn_step_sel
    import updn_ctr_pkg::*;
(
    input  logic  up_rise,
    input  logic  up_lvl,
    input  logic  dn_rise,
    input  logic  dn_lvl,
    input  logic  blocked,
    output step_e step
);
    logic up_ok, dn_ok;

    always_comb begin
        up_ok = up_rise & dn_lvl;
        dn_ok = dn_rise & up_lvl;
        if (blocked)             step = STEP_HOLD;
        else if (up_ok && dn_ok) step = STEP_HOLD;
        else if (up_ok)          step = STEP_INC;
        else if (dn_ok)          step = STEP_DEC;
        else                     step = STEP_HOLD;
    end
endmodule

// File: rtl/updn_next_val.sv
module updn_next_val
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cnt,
    input  step_e            step,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W-1:0] top_val;

    generate
        if (DECADE) begin : g_dec
            assign top_val = CNT_W'(9);
        end else begin : g_bin
            assign top_val = {CNT_W{1'b1}};
        end
    endgenerate

    always_comb begin
        case (step)
            STEP_INC: nxt = (cnt >= top_val) ? '0 : cnt + 1'b1;
            STEP_DEC: nxt = (cnt == '0) ? top_val : cnt - 1'b1;
            default:  nxt = cnt;
        endcase
    end
endmodule

// File: rtl/updn_flags.sv
module updn_flags
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] q,
    input  logic             up_in,
    input  logic             dn_in,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [CNT_W-1:0] TOP_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    always_comb begin
        carry_n  = ~((q == TOP_VAL) & ~up_in);
        borrow_n = ~((q == '0) & ~dn_in);
    end
endmodule

// File: rtl/updn_dual_ctr.sv
module updn_dual_ctr
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load_n,
    input  logic [CNT_W-1:0] jam,
    input  logic             up_in,
    input  logic             dn_in,
    output logic [CNT_W-1:0] q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int N_CH = 2;

    logic [N_CH-1:0] raw_in, lvl, rise;
    step_e           step;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cnt_q;
    ctr_state_t      st_d, st_q;

    assign raw_in = {dn_in, up_in};

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
            updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .clear (clear),
                .din   (raw_in[ch]),
                .level (lvl[ch]),
                .rise  (rise[ch])
            );
        end
    endgenerate

    updn_step_sel u_sel (
        .up_rise (rise[0]),
        .up_lvl  (lvl[0]),
        .dn_rise (rise[1]),
        .dn_lvl  (lvl[1]),
        .blocked (~load_n),
        .step    (step)
    );

    updn_next_val #(.DECADE(DECADE)) u_nxt (
        .cnt  (cnt_q),
        .step (step),
        .nxt  (nxt)
    );

    always_comb begin
        st_d = st_q;
        if (!load_n) st_d.cnt = jam;
        else         st_d.cnt = nxt;
    end

    always_ff @(posedge clk or posedge clear) begin
        if (clear) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    // immediate override path: clear, then load, then stored count
    always_comb begin
        if (clear)        q = '0;
        else if (!load_n) q = jam;
        else              q = cnt_q;
    end

    updn_flags #(.DECADE(DECADE)) u_flags (
        .q        (q),
        .up_in    (up_in),
        .dn_in    (dn_in),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );
endmodule

// File: rtl/updn_dual_ctr_chk.sv
module updn_dual_ctr_chk
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic             clk,
    input logic             clear,
    input logic             load_n,
    input logic [CNT_W-1:0] jam,
    input logic             up_in,
    input logic             dn_in,
    input logic [CNT_W-1:0] q,
    input logic             carry_n,
    input logic             borrow_n,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] TOP_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (clear) armed <= 1'b1;
    end

    function automatic logic [CNT_W-1:0] up1(input logic [CNT_W-1:0] v);
        return (v >= TOP_VAL) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] dn1(input logic [CNT_W-1:0] v);
        return (v == '0) ? TOP_VAL : v - 1'b1;
    endfunction

    always @(negedge clk) begin
        if (armed && clear) begin
            // R1
            clr_zero_chk: assert (q == '0);
        end
        if (armed && !clear && !load_n) begin
            // R2
            load_jam_chk: assert (q == jam);
        end
    end

    // R3 R4 R7 R8
    count_step_chk: assert property (@(posedge clk) disable iff (clear || !armed)
        ($past(load_n) && load_n) |->
            (cnt_q == $past(cnt_q)) || (cnt_q == up1($past(cnt_q))) || (cnt_q == dn1($past(cnt_q))));

    // R9
    carry_low_chk: assert property (@(posedge clk) disable iff (clear || !armed)
        !carry_n |-> (!up_in && q == TOP_VAL));

    // R10
    borrow_low_chk: assert property (@(posedge clk) disable iff (clear || !armed)
        !borrow_n |-> (!dn_in && q == '0));
endmodule

bind updn_dual_ctr updn_dual_ctr_chk #(.DECADE(DECADE)) u_chk (
    .clk      (clk),
    .clear    (clear),
    .load_n   (load_n),
    .jam      (jam),
    .up_in    (up_in),
    .dn_in    (dn_in),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .cnt_q    (cnt_q)
);

// File: tb/test_updn_dual_ctr.sv
module test_updn_dual_ctr;
    logic       clk = 1'b0;
    logic       clear, load_n, up_in, dn_in;
    logic [3:0] jam;
    logic [3:0] q_dec, q_bin;
    logic       cy_dec, bw_dec, cy_bin, bw_bin;

    always #5 clk = ~clk;

    updn_dual_ctr #(.DECADE(1'b1)) i_updn_dual_ctr (
        .clk(clk), .clear(clear), .load_n(load_n), .jam(jam),
        .up_in(up_in), .dn_in(dn_in), .q(q_dec), .carry_n(cy_dec), .borrow_n(bw_dec));

    updn_dual_ctr #(.DECADE(1'b0)) i_updn_dual_ctr_bin (
        .clk(clk), .clear(clear), .load_n(load_n), .jam(jam),
        .up_in(up_in), .dn_in(dn_in), .q(q_bin), .carry_n(cy_bin), .borrow_n(bw_bin));

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";
    int    m_cnt[2] = '{0, 0};
    bit    hu[3] = '{1, 1, 1};
    bit    hd[3] = '{1, 1, 1};

    function automatic int step_val(int c, int maxv, int dir);
        if (dir > 0) return (c >= maxv) ? 0 : c + 1;
        if (dir < 0) return (c == 0) ? maxv : c - 1;
        return c;
    endfunction

    // behavioural model: three-deep sample history, priority clear > load > count
    always @(posedge clk) begin
        bit eu, ed;
        int dir;
        if (clear) begin
            m_cnt = '{0, 0};
            hu = '{1, 1, 1};
            hd = '{1, 1, 1};
        end else begin
            eu  = hu[1] && !hu[2] && hd[1];
            ed  = hd[1] && !hd[2] && hu[1];
            dir = (eu && !ed) ? 1 : (ed && !eu) ? -1 : 0;
            for (int k = 0; k < 2; k++) begin
                if (!load_n) m_cnt[k] = jam;
                else         m_cnt[k] = step_val(m_cnt[k], k ? 15 : 9, dir);
            end
            hu[2] = hu[1]; hu[1] = hu[0]; hu[0] = up_in;
            hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = dn_in;
        end
    end

    task automatic check_one(int k, logic [3:0] aq, logic acy, logic abw);
        int    maxv = k ? 15 : 9;
        int    eq   = clear ? 0 : (!load_n ? int'(jam) : m_cnt[k]);
        bit    ecy  = !(eq == maxv && !up_in);
        bit    ebw  = !(eq == 0 && !dn_in);
        string qreq = (k == 1 && cur_req == "R7") ? "R8" : cur_req;
        compared++;
        if (int'(aq) != eq || acy != ecy || abw != ebw) mismatched++;
        if (int'(aq) != eq)
            $display("FAIL %s inst%0d q: actual %0d expected %0d", qreq, k, aq, eq);
        if (acy != ecy)
            $display("FAIL R9 inst%0d carry_n: actual %0b expected %0b", k, acy, ecy);
        if (abw != ebw)
            $display("FAIL R10 inst%0d borrow_n: actual %0b expected %0b", k, abw, ebw);
    endtask

    always @(negedge clk) begin
        #3;
        check_one(0, q_dec, cy_dec, bw_dec);
        check_one(1, q_bin, cy_bin, bw_bin);
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        @(negedge clk) up_in = 1'b0;
        wait_n(3);
        up_in = 1'b1;
        wait_n(4);
    endtask

    task automatic pulse_dn();
        @(negedge clk) dn_in = 1'b0;
        wait_n(3);
        dn_in = 1'b1;
        wait_n(4);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear = 1'b1; load_n = 1'b1; up_in = 1'b1; dn_in = 1'b1; jam = 4'd0;
        cur_req = "R11";
        wait_n(3);
        @(negedge clk) clear = 1'b0;
        wait_n(5);
        cur_req = "R3";
        repeat (3) pulse_up();
        cur_req = "R7";
        repeat (10) pulse_up();
        cur_req = "R4";
        repeat (4) pulse_dn();
        cur_req = "R7";
        repeat (12) pulse_dn();
        cur_req = "R2";
        @(negedge clk) begin load_n = 1'b0; jam = 4'd5; end
        wait_n(2);
        up_in = 1'b0; wait_n(3); up_in = 1'b1; wait_n(3);
        dn_in = 1'b0; wait_n(3); dn_in = 1'b1; wait_n(2);
        jam = 4'd12; wait_n(2);
        load_n = 1'b1; wait_n(3);
        cur_req = "R7";
        pulse_up();
        cur_req = "R2";
        @(negedge clk) begin load_n = 1'b0; jam = 4'd13; end
        wait_n(1);
        load_n = 1'b1; wait_n(2);
        cur_req = "R7";
        pulse_dn();
        cur_req = "R1";
        @(negedge clk) begin load_n = 1'b0; jam = 4'd7; end
        wait_n(1);
        clear = 1'b1; wait_n(3);
        clear = 1'b0; wait_n(2);
        load_n = 1'b1; wait_n(3);
        cur_req = "R5";
        @(negedge clk) dn_in = 1'b0;
        wait_n(2);
        up_in = 1'b0; wait_n(3); up_in = 1'b1; wait_n(4);
        dn_in = 1'b1; wait_n(5);
        @(negedge clk) up_in = 1'b0;
        wait_n(2);
        dn_in = 1'b0; wait_n(3); dn_in = 1'b1; wait_n(4);
        up_in = 1'b1; wait_n(5);
        cur_req = "R6";
        @(negedge clk) begin up_in = 1'b0; dn_in = 1'b0; end
        wait_n(3);
        up_in = 1'b1; dn_in = 1'b1; wait_n(6);
        cur_req = "R11";
        @(negedge clk) begin clear = 1'b1; up_in = 1'b0; end
        wait_n(2);
        up_in = 1'b1; wait_n(2);
        clear = 1'b0; wait_n(6);
        @(negedge clk) begin clear = 1'b1; up_in = 1'b0; end
        wait_n(2);
        clear = 1'b0; wait_n(2);
        cur_req = "R3";
        up_in = 1'b1; wait_n(6);
        cur_req = "R8";
        @(negedge clk) begin load_n = 1'b0; jam = 4'd15; end
        wait_n(1);
        load_n = 1'b1; wait_n(2);
        pulse_up();
        pulse_dn();
        wait_n(3);
        finish_run();
    end
endmodule